// File: doc/BRIEF.md
# Four-Bank SDRAM Timing Guard

This block sits in a memory controller in front of the command issue stage of a double-data-rate SDRAM with four banks. Each cycle the scheduler may present one candidate command with a bank number. The guard replies in the same cycle with exactly one of three verdicts. Accept means the command may go to the device now. Stall means the command is legal for the bank state but a spacing limit is not yet met, so the scheduler should retry later. Error means the command makes no sense for the current bank state. Only an accepted command updates the guard's bank states and counters.

All limits arrive on configuration inputs as clock counts. Software converts each nanosecond limit to clocks by dividing by the clock period and rounding any fraction up. Two limits are derived inside the block. The activate-to-write delay is the activate-to-read delay minus two, but never less than two. The write recovery before an automatic precharge is always CAS latency plus one clock. The guard also tracks how long each bank has been open and raises a warning when a bank stays open past a programmable clock count, which corresponds to the maximum row-active time.

Top module: `bank_timing_guard`

## Requirements
- R1: When cmd_valid is high, exactly one of cmd_ok, cmd_stall and cmd_err is high in the same cycle; when cmd_valid is low, all three are low. cmd_code encoding: 1 activate, 2 read, 3 write, 4 precharge one bank, 5 precharge all banks, 6 mode register write; cmd_bank selects bank 0 to 3, and bit i of bank_open and of open_warn belongs to bank i.
- R2: An activate to an open bank, a read or write to an idle bank, a mode write while any bank is open, and the codes 0 and 7 give cmd_err and change no bank state.
- R3: A precharge to an idle bank, or a precharge-all while no bank is open, is accepted at once and changes nothing.
- R4: A read is stalled until cfg_trcd clocks after its bank's activate. A write is stalled until max(cfg_trcd-2, 2) clocks after that activate.
- R5: An activate is stalled until max(cfg_trc, cfg_tras+cfg_trp) clocks after the previous activate of the same bank and until cfg_trp clocks after that bank's precharge. A precharge is stalled until cfg_tras clocks after the bank's activate.
- R6: An activate is stalled until cfg_trrd clocks after the last accepted activate to any bank.
- R7: A read is stalled until cfg_burst+2 clocks after the last accepted write to any bank. A precharge is stalled until cfg_burst+cfg_twr clocks after a write to that bank and until cfg_burst clocks after a read to that bank.
- R8: A read or write with cmd_ap high closes its bank when accepted. The next activate of that bank waits cfg_burst+cfg_cl+1+cfg_trp clocks after a write, or cfg_burst+cfg_trp clocks after a read, besides the R5 spacing.
- R9: A mode write needs every bank idle and at least cfg_trp clocks since each bank's last precharge. After it is accepted, every command other than an error is stalled for cfg_tmrd clocks.
- R10: A precharge-all waits until every open bank meets its own precharge limits, then closes all open banks.
- R11: open_warn[i] is high in every cycle in which bank i is open and its last activate lies more than cfg_open_max clocks in the past. Closing the bank clears it in the next cycle.
- R12: After reset, all banks are idle, no warning is raised, and no spacing limit is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Candidate command present |
| cmd_code | input | 3 | Command code (see R1) |
| cmd_bank | input | 2 | Target bank |
| cmd_ap | input | 1 | Auto-precharge with a read or write |
| cfg_trc | input | 6 | Same-bank activate spacing, clocks |
| cfg_tras | input | 6 | Activate-to-precharge minimum, clocks |
| cfg_trcd | input | 6 | Activate-to-read delay, clocks |
| cfg_trp | input | 6 | Precharge-to-activate delay, clocks |
| cfg_trrd | input | 6 | Cross-bank activate spacing, clocks |
| cfg_twr | input | 6 | Last write data to precharge, clocks |
| cfg_tmrd | input | 6 | Mode write to next command, clocks |
| cfg_cl | input | 6 | CAS latency, clocks |
| cfg_burst | input | 6 | Data clocks of one burst |
| cfg_open_max | input | 16 | Longest allowed open time, clocks |
| cmd_ok | output | 1 | Command accepted this cycle |
| cmd_stall | output | 1 | Command legal but too early |
| cmd_err | output | 1 | Command illegal for bank state |
| bank_open | output | 4 | Per-bank open flag |
| open_warn | output | 4 | Per-bank open-too-long warning |

## Verification
The open-time warning and a precharge can act on the same bank in the same cycle. The bench provokes this by precharging a bank in the exact cycle where one more clock would raise its warning, and judges that the warning never appears, while a second bank opened later still warns on schedule. A second overlap occurs when several spacing limits expire together. The bench sets cfg_trc above tRAS+tRP and also lets write recovery outlast tRAS, so the limit that wins in each case decides which first-accept cycle is observed.

// File: rtl/bkg_pkg.sv
package bkg_pkg;

    localparam int NBANK   = 4;
    localparam int BA_W    = $clog2(NBANK);
    localparam int TW      = 6;          // width of a configured limit
    localparam int CW      = TW + 2;     // counter width, holds sums of limits
    localparam int OPEN_W  = 16;
    localparam int WR2RD_GAP = 2;        // clocks from last write data to read

    typedef enum logic [2:0] {
        CMD_ACT  = 3'd1,
        CMD_RD   = 3'd2,
        CMD_WR   = 3'd3,
        CMD_PRE  = 3'd4,
        CMD_PREA = 3'd5,
        CMD_MODE = 3'd6
    } cmd_e;

    typedef logic [CW-1:0] cnt_t;

    // derived spacing limits, all in clocks
    typedef struct packed {
        cnt_t rc;
        cnt_t ras;
        cnt_t rcd_rd;
        cnt_t rcd_wr;
        cnt_t rp;
        cnt_t rrd;
        cnt_t rd2pre;
        cnt_t wr2pre;
        cnt_t wr2rd;
        cnt_t wrap_rp;
        cnt_t rdap_rp;
        cnt_t mrd;
    } lim_t;

    typedef struct packed {
        logic open;
        logic rc_rdy;
        logic rp_rdy;
        logic rd_rdy;
        logic wr_rdy;
        logic pre_rdy;
        logic warn;
    } bank_stat_t;

    function automatic cnt_t widen(logic [TW-1:0] v);
        return cnt_t'(v);
    endfunction

    function automatic cnt_t umax(cnt_t a, cnt_t b);
        return (a > b) ? a : b;
    endfunction

    // A request of n clocks made in cycle t permits the command in cycle t+n.
    // The stored value counts remaining stall cycles; a new request never
    // shortens a pending one.
    function automatic cnt_t next_wait(cnt_t cur, cnt_t req);
        cnt_t dec;
        cnt_t ld;
        dec = (cur != '0) ? cur - cnt_t'(1) : '0;
        ld  = (req != '0) ? req - cnt_t'(1) : '0;
        return umax(dec, ld);
    endfunction

endpackage

// File: rtl/bkg_limits.sv
module bkg_limits
    import bkg_pkg::*;
(
    input  logic [TW-1:0] cfg_trc,
    input  logic [TW-1:0] cfg_tras,
    input  logic [TW-1:0] cfg_trcd,
    input  logic [TW-1:0] cfg_trp,
    input  logic [TW-1:0] cfg_trrd,
    input  logic [TW-1:0] cfg_twr,
    input  logic [TW-1:0] cfg_tmrd,
    input  logic [TW-1:0] cfg_cl,
    input  logic [TW-1:0] cfg_burst,
    output lim_t          lim
);

    cnt_t trcd_w;
    cnt_t burst_w;
    cnt_t trp_w;

    always_comb begin
        trcd_w  = widen(cfg_trcd);
        burst_w = widen(cfg_burst);
        trp_w   = widen(cfg_trp);

        lim.rc      = umax(widen(cfg_trc), widen(cfg_tras) + trp_w);
        lim.ras     = widen(cfg_tras);
        lim.rcd_rd  = trcd_w;
        lim.rcd_wr  = (trcd_w >= cnt_t'(4)) ? trcd_w - cnt_t'(2) : cnt_t'(2);
        lim.rp      = trp_w;
        lim.rrd     = widen(cfg_trrd);
        lim.rd2pre  = burst_w;
        lim.wr2pre  = burst_w + widen(cfg_twr);
        lim.wr2rd   = burst_w + cnt_t'(WR2RD_GAP);
        lim.wrap_rp = burst_w + widen(cfg_cl) + cnt_t'(1) + trp_w;
        lim.rdap_rp = burst_w + trp_w;
        lim.mrd     = widen(cfg_tmrd);
    end

endmodule

// File: rtl/bkg_wait_ctr.sv
module bkg_wait_ctr
    import bkg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  cnt_t req,
    output logic rdy
);

    cnt_t remain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
        end else begin
            remain_q <= next_wait(remain_q, load ? req : '0);
        end
    end

    assign rdy = (remain_q == '0);

endmodule

// File: rtl/bkg_bank.sv
module bkg_bank
    import bkg_pkg::*;
#(
    parameter int AGE_W = OPEN_W
) (
    input  logic             clk,
    input  logic             rst,
    input  lim_t             lim,
    input  logic [AGE_W-1:0] open_max,
    input  logic             do_act,
    input  logic             do_rd,
    input  logic             do_wr,
    input  logic             do_pre,
    input  logic             ap,
    output bank_stat_t       stat
);

    logic             open_q;
    logic [AGE_W-1:0] age_q;
    logic             auto_close;
    logic             close;
    cnt_t             rp_req;
    cnt_t             pre_req;

    assign auto_close = (do_rd | do_wr) & ap;
    assign close      = do_pre | auto_close;

    always_comb begin
        if (do_pre)      rp_req = lim.rp;
        else if (do_wr)  rp_req = lim.wrap_rp;
        else             rp_req = lim.rdap_rp;

        if (do_act)      pre_req = lim.ras;
        else if (do_wr)  pre_req = lim.wr2pre;
        else             pre_req = lim.rd2pre;
    end

    bkg_wait_ctr u_rc (
        .clk(clk), .rst(rst), .load(do_act), .req(lim.rc), .rdy(stat.rc_rdy)
    );
    bkg_wait_ctr u_rp (
        .clk(clk), .rst(rst), .load(close), .req(rp_req), .rdy(stat.rp_rdy)
    );
    bkg_wait_ctr u_rcd_rd (
        .clk(clk), .rst(rst), .load(do_act), .req(lim.rcd_rd), .rdy(stat.rd_rdy)
    );
    bkg_wait_ctr u_rcd_wr (
        .clk(clk), .rst(rst), .load(do_act), .req(lim.rcd_wr), .rdy(stat.wr_rdy)
    );
    bkg_wait_ctr u_pre (
        .clk(clk), .rst(rst), .load(do_act | do_rd | do_wr), .req(pre_req),
        .rdy(stat.pre_rdy)
    );

    // open flag and open age (age equals clocks since the activate)
    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            age_q  <= '0;
        end else if (do_act) begin
            open_q <= 1'b1;
            age_q  <= AGE_W'(1);
        end else if (close) begin
            open_q <= 1'b0;
            age_q  <= '0;
        end else if (open_q && (age_q != '1)) begin
            age_q  <= age_q + AGE_W'(1);
        end
    end

    assign stat.open = open_q;
    assign stat.warn = open_q && (age_q > open_max);

endmodule

// File: rtl/bank_timing_guard.sv
module bank_timing_guard
    import bkg_pkg::*;
#(
    parameter int AGE_W = OPEN_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_code,
    input  logic [BA_W-1:0]  cmd_bank,
    input  logic             cmd_ap,
    input  logic [TW-1:0]    cfg_trc,
    input  logic [TW-1:0]    cfg_tras,
    input  logic [TW-1:0]    cfg_trcd,
    input  logic [TW-1:0]    cfg_trp,
    input  logic [TW-1:0]    cfg_trrd,
    input  logic [TW-1:0]    cfg_twr,
    input  logic [TW-1:0]    cfg_tmrd,
    input  logic [TW-1:0]    cfg_cl,
    input  logic [TW-1:0]    cfg_burst,
    input  logic [AGE_W-1:0] cfg_open_max,
    output logic             cmd_ok,
    output logic             cmd_stall,
    output logic             cmd_err,
    output logic [NBANK-1:0] bank_open,
    output logic [NBANK-1:0] open_warn
);

    lim_t             lim;
    bank_stat_t       stat [NBANK];
    logic [NBANK-1:0] rc_rdy_v, rp_rdy_v, rd_rdy_v, wr_rdy_v, pre_rdy_v;
    logic             rrd_rdy, wr2rd_rdy, mrd_rdy;
    logic             state_ok, time_ok;
    logic             acc_act, acc_rd, acc_wr, acc_pre, acc_prea, acc_mode;

    bkg_limits u_limits (
        .cfg_trc(cfg_trc), .cfg_tras(cfg_tras), .cfg_trcd(cfg_trcd),
        .cfg_trp(cfg_trp), .cfg_trrd(cfg_trrd), .cfg_twr(cfg_twr),
        .cfg_tmrd(cfg_tmrd), .cfg_cl(cfg_cl), .cfg_burst(cfg_burst),
        .lim(lim)
    );

    // accepted-command strobes
    assign acc_act  = cmd_ok && (cmd_code == CMD_ACT);
    assign acc_rd   = cmd_ok && (cmd_code == CMD_RD);
    assign acc_wr   = cmd_ok && (cmd_code == CMD_WR);
    assign acc_pre  = cmd_ok && (cmd_code == CMD_PRE);
    assign acc_prea = cmd_ok && (cmd_code == CMD_PREA);
    assign acc_mode = cmd_ok && (cmd_code == CMD_MODE);

    for (genvar i = 0; i < NBANK; i++) begin : g_bank
        logic hit;
        assign hit = (cmd_bank == BA_W'(i));

        bkg_bank #(.AGE_W(AGE_W)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .lim     (lim),
            .open_max(cfg_open_max),
            .do_act  (acc_act && hit),
            .do_rd   (acc_rd && hit),
            .do_wr   (acc_wr && hit),
            .do_pre  (((acc_pre && hit) || acc_prea) && stat[i].open),
            .ap      (cmd_ap),
            .stat    (stat[i])
        );

        assign bank_open[i] = stat[i].open;
        assign open_warn[i] = stat[i].warn;
        assign rc_rdy_v[i]  = stat[i].rc_rdy;
        assign rp_rdy_v[i]  = stat[i].rp_rdy;
        assign rd_rdy_v[i]  = stat[i].rd_rdy;
        assign wr_rdy_v[i]  = stat[i].wr_rdy;
        assign pre_rdy_v[i] = stat[i].pre_rdy;
    end

    // limits shared by all banks
    bkg_wait_ctr u_rrd (
        .clk(clk), .rst(rst), .load(acc_act), .req(lim.rrd), .rdy(rrd_rdy)
    );
    bkg_wait_ctr u_wr2rd (
        .clk(clk), .rst(rst), .load(acc_wr), .req(lim.wr2rd), .rdy(wr2rd_rdy)
    );
    bkg_wait_ctr u_mrd (
        .clk(clk), .rst(rst), .load(acc_mode), .req(lim.mrd), .rdy(mrd_rdy)
    );

    // verdict: state legality first, spacing second
    always_comb begin
        state_ok = 1'b1;
        time_ok  = 1'b1;
        case (cmd_code)
            CMD_ACT: begin
                state_ok = !bank_open[cmd_bank];
                time_ok  = rc_rdy_v[cmd_bank] && rp_rdy_v[cmd_bank] && rrd_rdy;
            end
            CMD_RD: begin
                state_ok = bank_open[cmd_bank];
                time_ok  = rd_rdy_v[cmd_bank] && wr2rd_rdy;
            end
            CMD_WR: begin
                state_ok = bank_open[cmd_bank];
                time_ok  = wr_rdy_v[cmd_bank];
            end
            CMD_PRE: begin
                time_ok  = !bank_open[cmd_bank] || pre_rdy_v[cmd_bank];
            end
            CMD_PREA: begin
                time_ok  = &(~bank_open | pre_rdy_v);
            end
            CMD_MODE: begin
                state_ok = (bank_open == '0);
                time_ok  = &rp_rdy_v;
            end
            default: begin
                state_ok = 1'b0;
            end
        endcase
        time_ok = time_ok && mrd_rdy;
    end

    assign cmd_err   = cmd_valid && !state_ok;
    assign cmd_stall = cmd_valid && state_ok && !time_ok;
    assign cmd_ok    = cmd_valid && state_ok && time_ok;

endmodule

// File: rtl/bank_timing_guard_chk.sv
module bank_timing_guard_chk
    import bkg_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cmd_valid,
    input logic [2:0]       cmd_code,
    input logic [BA_W-1:0]  cmd_bank,
    input logic [TW-1:0]    cfg_trrd,
    input logic             cmd_ok,
    input logic             cmd_stall,
    input logic             cmd_err,
    input logic [NBANK-1:0] bank_open,
    input logic [NBANK-1:0] open_warn
);

    logic [CW-1:0] since_act;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_act <= '1;
        end else if (cmd_ok && (cmd_code == CMD_ACT)) begin
            since_act <= CW'(1);
        end else if (since_act != '1) begin
            since_act <= since_act + CW'(1);
        end
    end

    assert_one_verdict_R1: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> $countones({cmd_ok, cmd_stall, cmd_err}) == 1);

    assert_no_verdict_idle_R1: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |-> !(cmd_ok || cmd_stall || cmd_err));

    assert_err_keeps_state_R2: assert property (@(posedge clk) disable iff (rst)
        cmd_err |=> $stable(bank_open));

    assert_act_only_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_ok && cmd_code == CMD_ACT) |-> !bank_open[cmd_bank]);

    assert_act_opens_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_ok && cmd_code == CMD_ACT) |=> bank_open[$past(cmd_bank)]);

    assert_column_only_open_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_ok && (cmd_code == CMD_RD || cmd_code == CMD_WR)) |-> bank_open[cmd_bank]);

    assert_mode_all_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd_ok && cmd_code == CMD_MODE) |-> bank_open == '0);

    assert_act_spacing_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd_ok && cmd_code == CMD_ACT) |-> since_act >= CW'(cfg_trrd));

    assert_warn_needs_open_R11: assert property (@(posedge clk) disable iff (rst)
        (open_warn & ~bank_open) == '0);

    assert_prea_closes_R10: assert property (@(posedge clk) disable iff (rst)
        (cmd_ok && cmd_code == CMD_PREA) |=> bank_open == '0);

endmodule

bind bank_timing_guard bank_timing_guard_chk chk_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_bank(cmd_bank), .cfg_trrd(cfg_trrd), .cmd_ok(cmd_ok),
    .cmd_stall(cmd_stall), .cmd_err(cmd_err), .bank_open(bank_open),
    .open_warn(open_warn)
);

// File: tb/bank_timing_guard_tb_top.sv
module bank_timing_guard_tb_top;
    import bkg_pkg::*;

    localparam logic [2:0] V_OK    = 3'b100;
    localparam logic [2:0] V_STALL = 3'b010;
    localparam logic [2:0] V_ERR   = 3'b001;

    logic              clk = 1'b0;
    logic              rst;
    logic              cmd_valid;
    logic [2:0]        cmd_code;
    logic [BA_W-1:0]   cmd_bank;
    logic              cmd_ap;
    logic [TW-1:0]     cfg_trc, cfg_tras, cfg_trcd, cfg_trp, cfg_trrd;
    logic [TW-1:0]     cfg_twr, cfg_tmrd, cfg_cl, cfg_burst;
    logic [OPEN_W-1:0] cfg_open_max;
    logic              cmd_ok, cmd_stall, cmd_err;
    logic [NBANK-1:0]  bank_open, open_warn;

    typedef struct {
        logic [2:0] verdict;
        string      tag;
    } sb_t;

    sb_t sbq[$];
    sb_t mon_item;
    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #4 clk = ~clk;

    bank_timing_guard dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_bank(cmd_bank), .cmd_ap(cmd_ap), .cfg_trc(cfg_trc),
        .cfg_tras(cfg_tras), .cfg_trcd(cfg_trcd), .cfg_trp(cfg_trp),
        .cfg_trrd(cfg_trrd), .cfg_twr(cfg_twr), .cfg_tmrd(cfg_tmrd),
        .cfg_cl(cfg_cl), .cfg_burst(cfg_burst), .cfg_open_max(cfg_open_max),
        .cmd_ok(cmd_ok), .cmd_stall(cmd_stall), .cmd_err(cmd_err),
        .bank_open(bank_open), .open_warn(open_warn)
    );

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    // monitor: pops one expected verdict for every presented command
    always @(negedge clk) begin
        if (!rst && cmd_valid && !done) begin
            if (sbq.size() == 0) begin
                check("R1 unexpected command", 32'd1, 32'd0);
            end else begin
                mon_item = sbq.pop_front();
                check(mon_item.tag, {29'd0, cmd_ok, cmd_stall, cmd_err},
                      {29'd0, mon_item.verdict});
            end
        end
    end

    // driver: presents one command for one cycle
    task automatic issue(logic [2:0] code, int bank, logic ap,
                         logic [2:0] verdict, string tag);
        sb_t it;
        cmd_valid = 1'b1;
        cmd_code  = code;
        cmd_bank  = BA_W'(bank);
        cmd_ap    = ap;
        it.verdict = verdict;
        it.tag     = tag;
        sbq.push_back(it);
        @(posedge clk);
        #1;
    endtask

    // retries a command; first accept exactly gap cycles after the last command
    task automatic expect_gap(logic [2:0] code, int bank, logic ap, int gap, string tag);
        for (int k = 1; k < gap; k++) issue(code, bank, ap, V_STALL, tag);
        issue(code, bank, ap, V_OK, tag);
    endtask

    task automatic idle(int n);
        cmd_valid = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic look_open(logic [NBANK-1:0] exp, string tag);
        cmd_valid = 1'b0;
        @(negedge clk);
        check(tag, {28'd0, bank_open}, {28'd0, exp});
        check("R1 no verdict when idle", {29'd0, cmd_ok, cmd_stall, cmd_err}, 32'd0);
        @(posedge clk);
        #1;
    endtask

    task automatic look_warn(logic [NBANK-1:0] exp, string tag);
        cmd_valid = 1'b0;
        @(negedge clk);
        check(tag, {28'd0, open_warn}, {28'd0, exp});
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        cfg_trc = 6'd20; cfg_tras = 6'd12; cfg_trcd = 6'd6; cfg_trp = 6'd6;
        cfg_trrd = 6'd4; cfg_twr = 6'd6; cfg_tmrd = 6'd4; cfg_cl = 6'd5;
        cfg_burst = 6'd2; cfg_open_max = 16'd40;
        rst = 1'b1; cmd_valid = 1'b0; cmd_code = '0; cmd_bank = '0; cmd_ap = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R12 reset state
        look_open(4'b0000, "R12 banks idle after reset");
        look_warn(4'b0000, "R12 no warning after reset");

        // R9 mode write then tMRD hold-off (T = first ACT)
        issue(CMD_MODE, 0, 1'b0, V_OK, "R9 mode write from reset");
        expect_gap(CMD_ACT, 0, 1'b0, 4, "R9 tMRD before activate");
        expect_gap(CMD_ACT, 1, 1'b0, 4, "R6 activate other bank after tRRD");
        expect_gap(CMD_RD, 0, 1'b0, 2, "R4 activate-to-read tRCD");
        expect_gap(CMD_WR, 1, 1'b0, 2, "R4 activate-to-write tRCD-2");
        expect_gap(CMD_RD, 0, 1'b0, 4, "R7 write-to-read burst+2");
        expect_gap(CMD_PRE, 0, 1'b0, 2, "R7 read-to-precharge burst");
        expect_gap(CMD_ACT, 0, 1'b0, 6, "R5 precharge-to-activate tRP");
        expect_gap(CMD_PREA, 0, 1'b0, 12, "R10 precharge-all waits tRAS of newest bank");
        look_open(4'b0000, "R10 precharge-all closes every bank");
        expect_gap(CMD_MODE, 0, 1'b0, 5, "R9 mode write waits tRP after precharge");
        idle(4);

        // R2 illegal commands, R3 no-op precharges
        issue(CMD_RD, 3, 1'b0, V_ERR, "R2 read to idle bank");
        issue(3'd0, 1, 1'b0, V_ERR, "R2 code 0 is illegal");
        issue(3'd7, 2, 1'b0, V_ERR, "R2 code 7 is illegal");
        issue(CMD_WR, 1, 1'b1, V_ERR, "R2 write to idle bank");
        look_open(4'b0000, "R2 errors leave banks idle");
        issue(CMD_PRE, 2, 1'b0, V_OK, "R3 precharge idle bank");
        issue(CMD_PREA, 0, 1'b0, V_OK, "R3 precharge-all with no bank open");
        look_open(4'b0000, "R3 no-op precharges change nothing");

        // R5 programmed tRC above tRAS+tRP (S = this ACT)
        issue(CMD_ACT, 2, 1'b0, V_OK, "R5 activate bank 2");
        expect_gap(CMD_ACT, 3, 1'b0, 4, "R6 activate bank 3 after tRRD");
        idle(7);
        issue(CMD_PRE, 2, 1'b0, V_OK, "R5 precharge at tRAS");
        issue(CMD_ACT, 3, 1'b0, V_ERR, "R2 activate to open bank");
        issue(CMD_MODE, 0, 1'b0, V_ERR, "R2 mode write with bank open");
        expect_gap(CMD_ACT, 2, 1'b0, 6, "R5 same-bank activate waits tRC");

        // R8 auto-precharge
        issue(CMD_WR, 3, 1'b1, V_OK, "R8 write with auto-precharge");
        issue(CMD_RD, 3, 1'b0, V_ERR, "R8 bank closed by auto-precharge");
        expect_gap(CMD_ACT, 3, 1'b0, 13, "R8 write auto-precharge burst+CL+1+tRP");
        issue(CMD_RD, 2, 1'b1, V_OK, "R8 read with auto-precharge");
        expect_gap(CMD_ACT, 2, 1'b0, 8, "R8 read auto-precharge burst+tRP");

        // R11 warning versus precharge in the same cycle
        idle(30);
        issue(CMD_PRE, 3, 1'b0, V_OK, "R11 precharge bank 3 at open age 40");
        look_warn(4'b0000, "R11 closed bank never warns");
        idle(7);
        look_warn(4'b0000, "R11 bank 2 at open age 40");
        look_warn(4'b0100, "R11 bank 2 at open age 41");
        issue(CMD_PRE, 2, 1'b0, V_OK, "R11 precharge warned bank");
        look_warn(4'b0000, "R11 warning cleared on close");

        // R7 write recovery outlasting tRAS
        issue(CMD_ACT, 0, 1'b0, V_OK, "R5 activate bank 0 again");
        idle(11);
        issue(CMD_WR, 0, 1'b0, V_OK, "R7 write bank 0");
        expect_gap(CMD_PRE, 0, 1'b0, 8, "R7 write-to-precharge burst+tWR");
        look_open(4'b0000, "R7 all banks idle at end");

        @(negedge clk);
        check("R1 scoreboard drained", sbq.size(), 32'd0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule